// File: doc/BRIEF.md
# Port Configuration Lock Register

This block holds the configuration lock for a 16-pin I/O port. Software first writes a per-pin lock mask into the low half of the lock word. It then arms the lock with three full-word writes whose key bit goes 1, then 0, then 1, all carrying the same mask. When the third write lands, the key bit reads 1 and the mask becomes a freeze vector. The mask and the key then stay fixed until reset.

The block decodes a simple byte-addressed register bus with 32-bit data, byte enables, a write strobe and a read strobe. Read data is combinational. It also carries a minimal copy of the port's mode register (2 bits per pin) and two alternate-function words (4 bits per pin). The bench uses these to show that the freeze vector blocks writes to the fields of locked pins. The freeze vector is also exported as a port, so that other configuration logic can use it.

Register offsets are 0x00 (mode), 0x1C (lock), 0x20 (alternate function, pins 0 to 7) and 0x24 (alternate function, pins 8 to 15).

Top module: `gpio_cfg_lock`

## Requirements
- R1: After reset, every register reads 0 and the freeze output is 0.
- R2: At offset 0x1C, the read layout is as follows. Bits 15:0 are the lock mask, bit 16 is the key and bits 31:17 always read 0.
- R3: While the key is 0, a write to 0x1C updates the mask bytes whose byte enables are set. No write outside a completed sequence sets the key.
- R4: The key becomes 1 on the third write of the sequence key=1, key=0, key=1, provided all three are full-word writes (byte enables 4'hF) with equal bits 15:0. From that write on, the freeze output equals the mask.
- R5: If bits 15:0 of a sequence write differ from the previous step, the attempt is aborted.
- R6: A write to 0x1C with byte enables other than 4'hF aborts the attempt.
- R7: Writing a key value out of order aborts the attempt. A full-word key=1 write that aborts an attempt counts as step one of a new attempt.
- R8: Reads and writes at other offsets between sequence steps leave the attempt undisturbed.
- R9: Once locked, writes to 0x1C change neither the mask nor the key until reset.
- R10: A write to the mode word or to an alternate-function word leaves the fields of frozen pins unchanged and updates the fields of the other pins, byte enables permitting. Pin y owns mode bits [2y+1:2y], and alternate-function bits [4(y mod 8)+3:4(y mod 8)] of word 0x20 + 4*(y/8).
- R11: While the key is 0, the freeze output is 0 whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busBe | input | 4 | Byte enables of a write |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busRdata | output | 32 | Read data, 0 when busRd is low |
| pinFreeze | output | 16 | Per-pin freeze vector |

## Verification
The hardest state to reach is a half-finished attempt that a faulty write knocks back. This is especially so when the faulty write is itself a valid first step, because the tracker must then restart rather than fall idle. The stimulus aborts attempts in each way: a changed mask, a narrow write and a misordered key. It then continues with just enough writes to complete a lock only if the restart or the idle return happened as required, and reads the key between each step. Each lock ends the run's use of that reset. The sweep therefore resets before each of 18 masks, then writes inverted patterns into the mode and alternate-function words, so that every frozen field would visibly change if a write got through.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;

  // strobes from the sequence tracker to the register datapath
  typedef struct packed {
    logic [3:0] maskByteWr;  // write enable per byte of the lock mask
    logic       keySet;      // sequence completed on this write
  } lockStrobes_t;

  typedef enum logic [1:0] {
    SEQ_IDLE,   // no attempt in progress
    SEQ_ONE,    // key=1 step accepted
    SEQ_ZERO,   // key=1 then key=0 accepted
    SEQ_DONE    // locked until reset
  } seqState_t;

endpackage

// File: rtl/lock_seq_ctrl.sv
module lock_seq_ctrl
  import gpio_lock_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lockWr,
  input  logic [3:0]          wrBe,
  input  logic                wrKey,
  input  logic [NUM_PINS-1:0] wrMask,
  input  logic [NUM_PINS-1:0] curMask,
  output lockStrobes_t        strobes
);

  seqState_t state, stateNext;
  logic      fullWord;
  logic      sameMask;
  logic      restart;

  assign fullWord = (wrBe == 4'hF);
  assign sameMask = (wrMask == curMask);
  // a full key=1 write always qualifies as a first step
  assign restart  = fullWord && wrKey;

  always_comb begin
    stateNext = state;
    if (lockWr) begin
      unique case (state)
        SEQ_IDLE: if (restart) stateNext = SEQ_ONE;
        SEQ_ONE: begin
          if (fullWord && !wrKey && sameMask) stateNext = SEQ_ZERO;
          else if (restart)                   stateNext = SEQ_ONE;
          else                                stateNext = SEQ_IDLE;
        end
        SEQ_ZERO: begin
          if (restart && sameMask) stateNext = SEQ_DONE;
          else if (restart)        stateNext = SEQ_ONE;
          else                     stateNext = SEQ_IDLE;
        end
        SEQ_DONE: stateNext = SEQ_DONE;
        default:  stateNext = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes            = '0;
    strobes.maskByteWr = (lockWr && state != SEQ_DONE) ? wrBe : 4'h0;
    strobes.keySet     = lockWr && state == SEQ_ZERO && stateNext == SEQ_DONE;
  end

endmodule

// File: rtl/port_cfg_datapath.sv
module port_cfg_datapath
  import gpio_lock_pkg::*;
#(
  parameter int NUM_PINS  = 16,
  parameter int MODE_BITS = 2,
  parameter int AF_BITS   = 4,
  parameter int ADDR_W    = 6,
  parameter int MODE_OFS  = 'h00,
  parameter int LOCK_OFS  = 'h1C,
  parameter int AF_OFS    = 'h20
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic                          rdEn,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [31:0]                   wdata,
  input  logic [3:0]                    be,
  input  lockStrobes_t                  strobes,
  output logic [31:0]                   rdata,
  output logic [NUM_PINS-1:0]           freeze,
  output logic                          keyBit,
  output logic [NUM_PINS-1:0]           maskQ,
  output logic [NUM_PINS*MODE_BITS-1:0] modeQ
);

  localparam int MODE_W     = NUM_PINS * MODE_BITS;
  localparam int AF_W       = NUM_PINS * AF_BITS;
  localparam int MODE_WORDS = (MODE_W + 31) / 32;
  localparam int AF_WORDS   = (AF_W + 31) / 32;
  localparam int MODE_SPAN  = MODE_WORDS * 32;
  localparam int AF_SPAN    = AF_WORDS * 32;

  logic [AF_W-1:0]      afQ;
  logic [MODE_SPAN-1:0] modePad;
  logic [AF_SPAN-1:0]   afPad;

  // lock mask, written per byte while the tracker allows it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
    end else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (strobes.maskByteWr[i/8]) maskQ[i] <= wdata[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               keyBit <= 1'b0;
    else if (strobes.keySet) keyBit <= 1'b1;
  end

  assign freeze = keyBit ? maskQ : '0;

  // per-pin mode fields
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_mode
    localparam int LO   = p * MODE_BITS;
    localparam int WORD = LO / 32;
    localparam int BIT  = LO % 32;
    logic                 hit;
    logic [MODE_BITS-1:0] fieldQ;
    assign hit = wrEn && (addr == ADDR_W'(MODE_OFS + 4 * WORD))
                 && be[BIT/8] && !freeze[p];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    fieldQ <= '0;
      else if (hit) fieldQ <= wdata[BIT +: MODE_BITS];
    end
    assign modeQ[LO +: MODE_BITS] = fieldQ;
  end

  // per-pin alternate-function fields
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_af
    localparam int LO   = p * AF_BITS;
    localparam int WORD = LO / 32;
    localparam int BIT  = LO % 32;
    logic               hit;
    logic [AF_BITS-1:0] fieldQ;
    assign hit = wrEn && (addr == ADDR_W'(AF_OFS + 4 * WORD))
                 && be[BIT/8] && !freeze[p];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    fieldQ <= '0;
      else if (hit) fieldQ <= wdata[BIT +: AF_BITS];
    end
    assign afQ[LO +: AF_BITS] = fieldQ;
  end

  assign modePad = MODE_SPAN'(modeQ);
  assign afPad   = AF_SPAN'(afQ);

  always_comb begin
    rdata = '0;
    if (rdEn) begin
      for (int w = 0; w < MODE_WORDS; w++) begin
        if (addr == ADDR_W'(MODE_OFS + 4 * w)) rdata = modePad[w*32 +: 32];
      end
      for (int w = 0; w < AF_WORDS; w++) begin
        if (addr == ADDR_W'(AF_OFS + 4 * w)) rdata = afPad[w*32 +: 32];
      end
      if (addr == ADDR_W'(LOCK_OFS)) rdata = 32'({keyBit, maskQ});
    end
  end

endmodule

// File: rtl/gpio_cfg_lock.sv
module gpio_cfg_lock
  import gpio_lock_pkg::*;
#(
  parameter int NUM_PINS  = 16,
  parameter int MODE_BITS = 2,
  parameter int AF_BITS   = 4,
  parameter int ADDR_W    = 6,
  parameter int MODE_OFS  = 'h00,
  parameter int LOCK_OFS  = 'h1C,
  parameter int AF_OFS    = 'h20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWdata,
  input  logic [3:0]          busBe,
  input  logic                busWr,
  input  logic                busRd,
  output logic [31:0]         busRdata,
  output logic [NUM_PINS-1:0] pinFreeze
);

  localparam int KEY_POS = NUM_PINS;

  lockStrobes_t                  strobes;
  logic                          lockWr;
  logic                          keyBit;
  logic [NUM_PINS-1:0]           maskQ;
  logic [NUM_PINS*MODE_BITS-1:0] modeQ;

  assign lockWr = busWr && (busAddr == ADDR_W'(LOCK_OFS));

  lock_seq_ctrl #(
    .NUM_PINS(NUM_PINS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .lockWr  (lockWr),
    .wrBe    (busBe),
    .wrKey   (busWdata[KEY_POS]),
    .wrMask  (busWdata[NUM_PINS-1:0]),
    .curMask (maskQ),
    .strobes (strobes)
  );

  port_cfg_datapath #(
    .NUM_PINS (NUM_PINS),
    .MODE_BITS(MODE_BITS),
    .AF_BITS  (AF_BITS),
    .ADDR_W   (ADDR_W),
    .MODE_OFS (MODE_OFS),
    .LOCK_OFS (LOCK_OFS),
    .AF_OFS   (AF_OFS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (busWr),
    .rdEn   (busRd),
    .addr   (busAddr),
    .wdata  (busWdata),
    .be     (busBe),
    .strobes(strobes),
    .rdata  (busRdata),
    .freeze (pinFreeze),
    .keyBit (keyBit),
    .maskQ  (maskQ),
    .modeQ  (modeQ)
  );

endmodule

// File: rtl/gpio_cfg_lock_chk.sv
module gpio_cfg_lock_chk #(
  parameter int NUM_PINS  = 16,
  parameter int MODE_BITS = 2,
  parameter int ADDR_W    = 6,
  parameter int LOCK_OFS  = 'h1C
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [ADDR_W-1:0]             busAddr,
  input logic [31:0]                   busWdata,
  input logic [3:0]                    busBe,
  input logic                          busWr,
  input logic                          busRd,
  input logic [31:0]                   busRdata,
  input logic [NUM_PINS-1:0]           pinFreeze,
  input logic                          keyBit,
  input logic [NUM_PINS*MODE_BITS-1:0] modeQ
);

  localparam int KEY_POS = NUM_PINS;

  logic [NUM_PINS*MODE_BITS-1:0] modeFrz;
  logic                          lockRd;
  logic                          lockFullKeyWr;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_exp
    assign modeFrz[p*MODE_BITS +: MODE_BITS] = {MODE_BITS{pinFreeze[p]}};
  end

  assign lockRd        = busRd && busAddr == ADDR_W'(LOCK_OFS);
  assign lockFullKeyWr = busWr && busAddr == ADDR_W'(LOCK_OFS)
                         && busBe == 4'hF && busWdata[KEY_POS];

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    lockRd |-> busRdata[31:KEY_POS+1] == '0);

  assert_lock_sets_freeze_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(keyBit) |-> pinFreeze == $past(busWdata[NUM_PINS-1:0]));

  assert_lock_on_full_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(keyBit) |-> $past(lockFullKeyWr));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    keyBit |=> keyBit && $stable(pinFreeze));

  assert_frozen_mode_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    keyBit |=> ((modeQ ^ $past(modeQ)) & $past(modeFrz)) == '0);

  assert_no_freeze_unlocked_R11: assert property (@(posedge clk) disable iff (!rstN)
    !keyBit |-> pinFreeze == '0);

endmodule

bind gpio_cfg_lock gpio_cfg_lock_chk #(
  .NUM_PINS (NUM_PINS),
  .MODE_BITS(MODE_BITS),
  .ADDR_W   (ADDR_W),
  .LOCK_OFS (LOCK_OFS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busBe    (busBe),
  .busWr    (busWr),
  .busRd    (busRd),
  .busRdata (busRdata),
  .pinFreeze(pinFreeze),
  .keyBit   (keyBit),
  .modeQ    (modeQ)
);

// File: tb/test_gpio_cfg_lock.sv
module test_gpio_cfg_lock;

  localparam logic [5:0] MODE_A = 6'h00;
  localparam logic [5:0] LOCK_A = 6'h1C;
  localparam logic [5:0] AFLO_A = 6'h20;
  localparam logic [5:0] AFHI_A = 6'h24;

  logic        clk = 1'b0;
  logic        rstN;
  logic [5:0]  busAddr;
  logic [31:0] busWdata;
  logic [3:0]  busBe;
  logic        busWr;
  logic        busRd;
  logic [31:0] busRdata;
  logic [15:0] pinFreeze;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gpio_cfg_lock i_gpio_cfg_lock (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busBe(busBe), .busWr(busWr), .busRd(busRd), .busRdata(busRdata),
    .pinFreeze(pinFreeze)
  );

  function automatic logic [31:0] lockWord(input logic key, input logic [15:0] mask);
    return {15'b0, key, mask};
  endfunction

  // expected word: fields of frozen pins keep old bits, others take new
  function automatic logic [31:0] mergeExp(input logic [31:0] oldW, input logic [31:0] newW,
                                           input logic [15:0] mask, input int fw, input int base);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = mask[base + i/fw] ? oldW[i] : newW[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; busWr = 1'b0; busRd = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wrReg(input logic [5:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    busAddr = a; busWdata = d; busBe = b; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic checkReg(input string req, input logic [5:0] a, input logic [31:0] exp);
    busAddr = a; busRd = 1'b1;
    #1;
    check(req, busRdata, exp);
    busRd = 1'b0;
    #1;
  endtask

  task automatic wrKey(input logic key, input logic [15:0] mask);
    wrReg(LOCK_A, lockWord(key, mask), 4'hF);
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busAddr = '0; busWdata = '0; busBe = '0; busWr = 1'b0; busRd = 1'b0;
    doReset();

    // R1 reset state
    checkReg("R1 mode", MODE_A, 32'h0);
    checkReg("R1 lock", LOCK_A, 32'h0);
    checkReg("R1 aflo", AFLO_A, 32'h0);
    checkReg("R1 afhi", AFHI_A, 32'h0);
    check("R1 freeze", 32'(pinFreeze), 32'h0);

    // R3 byte-enabled mask writes, narrow key writes never set key
    wrReg(LOCK_A, 32'h0001_ABCD, 4'h1);
    checkReg("R3 low byte", LOCK_A, 32'h0000_00CD);
    wrReg(LOCK_A, 32'h0001_ABCD, 4'h6);
    checkReg("R3 high byte", LOCK_A, 32'h0000_ABCD);
    // R11 mask alone freezes nothing
    check("R11 freeze", 32'(pinFreeze), 32'h0);
    wrReg(MODE_A, 32'hFFFF_FFFF, 4'hF);
    checkReg("R11 mode write", MODE_A, 32'hFFFF_FFFF);

    // R2 reserved bits read zero even after all-ones write (step one only)
    wrReg(LOCK_A, 32'hFFFF_FFFF, 4'hF);
    checkReg("R2 reserved", LOCK_A, 32'h0000_FFFF);

    // R5 mismatched mask aborts; then a clean restart completes
    doReset();
    wrKey(1, 16'h1234); wrKey(0, 16'h1235);
    checkReg("R5 no key", LOCK_A, lockWord(0, 16'h1235));
    wrKey(1, 16'h1235);
    checkReg("R5 still no key", LOCK_A, lockWord(0, 16'h1235));
    wrKey(0, 16'h1235); wrKey(1, 16'h1235);
    checkReg("R4 locked after restart", LOCK_A, lockWord(1, 16'h1235));
    check("R4 freeze", 32'(pinFreeze), 32'h1235);

    // R5 mismatch on the third step: that write restarts as step one
    doReset();
    wrKey(1, 16'h00FF); wrKey(0, 16'h00FF); wrKey(1, 16'h00FE);
    checkReg("R5 third mismatch", LOCK_A, lockWord(0, 16'h00FE));
    wrKey(0, 16'h00FE); wrKey(1, 16'h00FE);
    checkReg("R7 restart completes", LOCK_A, lockWord(1, 16'h00FE));

    // R6 narrow write aborts
    doReset();
    wrKey(1, 16'h0F0F);
    wrReg(LOCK_A, lockWord(0, 16'h0F0F), 4'h3);
    wrKey(1, 16'h0F0F);
    checkReg("R6 narrow aborted", LOCK_A, lockWord(0, 16'h0F0F));
    wrKey(0, 16'h0F0F); wrKey(1, 16'h0F0F);
    checkReg("R6 later completes", LOCK_A, lockWord(1, 16'h0F0F));

    // R6 narrow final step does not lock
    doReset();
    wrKey(1, 16'h0F0F); wrKey(0, 16'h0F0F);
    wrReg(LOCK_A, lockWord(1, 16'h0F0F), 4'h7);
    checkReg("R6 narrow third", LOCK_A, lockWord(0, 16'h0F0F));
    check("R6 freeze", 32'(pinFreeze), 32'h0);

    // R7 repeated key=1 restarts as step one
    doReset();
    wrKey(1, 16'h8001); wrKey(1, 16'h8001); wrKey(0, 16'h8001); wrKey(1, 16'h8001);
    checkReg("R7 double one", LOCK_A, lockWord(1, 16'h8001));

    // R7 key=0 in place of third step goes idle
    doReset();
    wrKey(1, 16'h8001); wrKey(0, 16'h8001); wrKey(0, 16'h8001); wrKey(1, 16'h8001);
    checkReg("R7 zero zero", LOCK_A, lockWord(0, 16'h8001));
    wrKey(0, 16'h8001); wrKey(1, 16'h8001);
    checkReg("R7 resumes", LOCK_A, lockWord(1, 16'h8001));

    // R7 sequence starting with key=0 only counts from the next key=1
    doReset();
    wrKey(0, 16'h0010); wrKey(1, 16'h0010); wrKey(0, 16'h0010);
    checkReg("R7 two steps only", LOCK_A, lockWord(0, 16'h0010));

    // R8 other offsets between steps
    doReset();
    wrKey(1, 16'h4242);
    wrReg(MODE_A, 32'h1111_1111, 4'hF);
    checkReg("R8 mode between", MODE_A, 32'h1111_1111);
    wrKey(0, 16'h4242);
    wrReg(AFLO_A, 32'h2222_2222, 4'hF);
    wrKey(1, 16'h4242);
    checkReg("R8 locked", LOCK_A, lockWord(1, 16'h4242));

    // R9 locked register ignores writes
    wrKey(0, 16'h0000);
    checkReg("R9 key0 write", LOCK_A, lockWord(1, 16'h4242));
    wrReg(LOCK_A, 32'h0000_FFFF, 4'h3);
    checkReg("R9 narrow write", LOCK_A, lockWord(1, 16'h4242));
    wrKey(1, 16'h1111); wrKey(0, 16'h1111); wrKey(1, 16'h1111);
    checkReg("R9 new sequence", LOCK_A, lockWord(1, 16'h4242));
    check("R9 freeze", 32'(pinFreeze), 32'h4242);

    // R10 sweep of masks: frozen fields keep old values
    for (int k = 0; k < 18; k++) begin
      logic [15:0] m;
      if (k < 16) m = (16'h1 << k) | ((k >= 8) ? 16'h00F0 : 16'h0F00);
      else        m = (k == 16) ? 16'h0000 : 16'hFFFF;
      doReset();
      wrReg(MODE_A, 32'h5555_5555, 4'hF);
      wrReg(AFLO_A, 32'h1234_5678, 4'hF);
      wrReg(AFHI_A, 32'h9ABC_DEF0, 4'hF);
      wrKey(1, m); wrKey(0, m); wrKey(1, m);
      check("R4 sweep freeze", 32'(pinFreeze), 32'(m));
      wrReg(MODE_A, ~32'h5555_5555, 4'hF);
      wrReg(AFLO_A, ~32'h1234_5678, 4'hF);
      wrReg(AFHI_A, ~32'h9ABC_DEF0, 4'hF);
      checkReg("R10 mode", MODE_A, mergeExp(32'h5555_5555, ~32'h5555_5555, m, 2, 0));
      checkReg("R10 aflo", AFLO_A, mergeExp(32'h1234_5678, ~32'h1234_5678, m, 4, 0));
      checkReg("R10 afhi", AFHI_A, mergeExp(32'h9ABC_DEF0, ~32'h9ABC_DEF0, m, 4, 8));
    end

    // R10 byte enables still apply to unfrozen pins
    doReset();
    wrKey(1, 16'h0001); wrKey(0, 16'h0001); wrKey(1, 16'h0001);
    wrReg(MODE_A, 32'hFFFF_FFFF, 4'h1);
    checkReg("R10 byte enable", MODE_A, 32'h0000_00FC);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule